// File: doc/BRIEF.md
# Double-Buffered DAC Update Controller

This block keeps the settings for a bank of digital-to-analog converter channels: for each channel, a 16-bit code register plus three trim registers (range select, fine gain, offset). Software writes codes at any pace through a plain register-write port. The codes reach the converter-facing outputs only when a load command arrives. The load moves every channel at once, so all analog outputs step together.

The load and clear commands travel in two high bits of the write word. They can ride on any write. An address in the command-only region carries them without touching a register. A clear empties the staging codes, and a later load pushes the empty codes out. A one-cycle strobe marks each update of the parallel output codes for the downstream serializer. Trim registers feed their outputs directly, and they reset to neutral so that raw codes pass through unchanged.

Top module: `dacupd_ctrl`

## Requirements
- R1: A write that does not carry the load bit (write-data bit 31) never changes `out_code`.
- R2: A write with the load bit set copies every channel's staging code into `out_code` at the same clock edge. The new codes are visible in the cycle after the write.
- R3: Write-data bits 31 (load) and 30 (clear) always read back as 0, at every read address.
- R4: A write with the clear bit (write-data bit 30) sets every staging code to 0x0000. It leaves `out_code` and all trim registers unchanged.
- R5: Reading a code register returns the last value staged for that channel, not the value on `out_code`. Address layout: bit 5 set selects the command-only region, which reads as 0. Otherwise bits 4:2 give the channel and bits 1:0 give the register: 0 is the code, 1 is the range, 2 is fine gain, 3 is offset.
- R6: The range register is 2 bits wide. Codes 0, 1 and 2 are stored. A write of code 3 is ignored, and the register keeps its previous value.
- R7: The fine-gain register stores write-data bits 5:0 (signed, −32..+31 LSB), and the offset register stores bits 7:0 (signed, 1/8 LSB steps). Both read back zero-extended and drive their outputs from the cycle after the write.
- R8: After reset, all codes, outputs and trims are 0 (range code 0 is the neutral range), and `out_strobe` is low.
- R9: If a code write and the load bit come in the same write, the load takes the newly written code.
- R10: If the clear and load bits come with a code write, the written channel takes the written code, and every other channel loads 0x0000.
- R11: `out_strobe` is high for exactly the one cycle after each load write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write valid |
| wr_addr | input | 6 | Write address (channel, register, command region) |
| wr_data | input | 32 | Write word: [31] load, [30] clear, low bits register value |
| rd_addr | input | 6 | Read address, combinational read |
| rd_data | output | 32 | Read word |
| out_code | output | 128 | Loaded codes, channel n at bits 16n+15:16n |
| out_strobe | output | 1 | One-cycle pulse after a load |
| out_coarse | output | 16 | Range selects, 2 bits per channel |
| out_fine | output | 48 | Fine-gain trims, 6 bits per channel |
| out_ofs | output | 64 | Offset trims, 8 bits per channel |

## Verification
The hardest cases are the ones where a command and a register write share one write cycle. In those cases the load has to see the value being written, and a clear has to lose to that write on its own channel while wiping the others. The stimulus first fills the other channels with non-zero codes. It then issues a single write that carries code, clear and load together. A scoreboard predicts the full 128-bit output image for every load and compares it when the strobe appears. Further checks confirm that the reserved range code and plain clears leave the observable state alone.

// File: rtl/dacupd_pkg.sv
package dacupd_pkg;
   typedef enum logic [1:0] {
      SEL_CODE   = 2'd0,
      SEL_RANGE  = 2'd1,
      SEL_FINE   = 2'd2,
      SEL_OFS    = 2'd3
   } regsel_e;
endpackage

// File: rtl/dacupd_chan.sv
module dacupd_chan
   import dacupd_pkg::*;
#(
   parameter int DW     = 16,
   parameter int CG_W   = 2,
   parameter int FG_W   = 6,
   parameter int OF_W   = 8,
   parameter int CG_RSVD = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hit,
   input  regsel_e         wr_sel,
   input  logic [DW-1:0]   wr_val,
   input  logic            clr,
   input  logic            load,
   output logic [DW-1:0]   code_q,
   output logic [DW-1:0]   hold_q,
   output logic [CG_W-1:0] range_q,
   output logic [FG_W-1:0] fine_q,
   output logic [OF_W-1:0] ofs_q
);
   logic [DW-1:0] code_nxt;

   // clear first, then a same-cycle write to this channel wins (R10)
   always_comb begin
      code_nxt = clr ? '0 : code_q;
      if (wr_hit && wr_sel == SEL_CODE)
         code_nxt = wr_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         hold_q  <= '0;
         range_q <= '0;
         fine_q  <= '0;
         ofs_q   <= '0;
      end else begin
         code_q <= code_nxt;
         if (load)
            hold_q <= code_nxt;   // load sees the new staging value (R9)
         if (wr_hit && wr_sel == SEL_RANGE &&
             wr_val[CG_W-1:0] != CG_W'(CG_RSVD))
            range_q <= wr_val[CG_W-1:0];
         if (wr_hit && wr_sel == SEL_FINE)
            fine_q <= wr_val[FG_W-1:0];
         if (wr_hit && wr_sel == SEL_OFS)
            ofs_q <= wr_val[OF_W-1:0];
      end
   end
endmodule

// File: rtl/dacupd_rdmux.sv
module dacupd_rdmux
   import dacupd_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int DW    = 16,
   parameter int CG_W  = 2,
   parameter int FG_W  = 6,
   parameter int OF_W  = 8,
   parameter int BUS_W = 32,
   localparam int CH_W = $clog2(NCH),
   localparam int AW   = CH_W + 3
) (
   input  logic [AW-1:0]        rd_addr,
   input  logic [NCH*DW-1:0]    code_flat,
   input  logic [NCH*CG_W-1:0]  range_flat,
   input  logic [NCH*FG_W-1:0]  fine_flat,
   input  logic [NCH*OF_W-1:0]  ofs_flat,
   output logic [BUS_W-1:0]     rd_data
);
   logic [CH_W-1:0] ch;
   regsel_e         sel;

   assign ch  = rd_addr[AW-2:2];
   assign sel = regsel_e'(rd_addr[1:0]);

   always_comb begin
      rd_data = '0;
      if (!rd_addr[AW-1]) begin
         unique case (sel)
            SEL_CODE:  rd_data[DW-1:0]   = code_flat[ch*DW +: DW];
            SEL_RANGE: rd_data[CG_W-1:0] = range_flat[ch*CG_W +: CG_W];
            SEL_FINE:  rd_data[FG_W-1:0] = fine_flat[ch*FG_W +: FG_W];
            SEL_OFS:   rd_data[OF_W-1:0] = ofs_flat[ch*OF_W +: OF_W];
            default:   rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/dacupd_ctrl.sv
module dacupd_ctrl
   import dacupd_pkg::*;
#(
   parameter int NCH      = 8,
   parameter int DW       = 16,
   parameter int CG_W     = 2,
   parameter int FG_W     = 6,
   parameter int OF_W     = 8,
   parameter int CG_RSVD  = 3,
   parameter int BUS_W    = 32,
   parameter int LOAD_BIT = 31,
   parameter int CLR_BIT  = 30,
   localparam int CH_W    = $clog2(NCH),
   localparam int AW      = CH_W + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [BUS_W-1:0]     wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic [BUS_W-1:0]     rd_data,
   output logic [NCH*DW-1:0]    out_code,
   output logic                 out_strobe,
   output logic [NCH*CG_W-1:0]  out_coarse,
   output logic [NCH*FG_W-1:0]  out_fine,
   output logic [NCH*OF_W-1:0]  out_ofs
);
   initial begin
      if (NCH < 2 || (1 << CH_W) != NCH)
         $fatal(1, "NCH must be a power of two of at least 2");
      if (LOAD_BIT >= BUS_W || CLR_BIT >= LOAD_BIT || CLR_BIT <= DW)
         $fatal(1, "command bits must sit above the code field");
      if (FG_W > DW || OF_W > DW || CG_W > DW)
         $fatal(1, "trim fields must fit the code field");
      if (CG_RSVD >= (1 << CG_W))
         $fatal(1, "reserved range code out of field");
   end

   logic              cmd_load, cmd_clr, cmd_only;
   logic [CH_W-1:0]   wr_ch;
   regsel_e           wr_sel;
   logic [NCH*DW-1:0] data_flat;
   wire               unused_bus = ^wr_data[CLR_BIT-1:DW];

   assign cmd_load = wr_en && wr_data[LOAD_BIT];
   assign cmd_clr  = wr_en && wr_data[CLR_BIT];
   assign cmd_only = wr_addr[AW-1];
   assign wr_ch    = wr_addr[AW-2:2];
   assign wr_sel   = regsel_e'(wr_addr[1:0]);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dacupd_chan #(
         .DW(DW), .CG_W(CG_W), .FG_W(FG_W), .OF_W(OF_W), .CG_RSVD(CG_RSVD)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_en && !cmd_only && wr_ch == CH_W'(g)),
         .wr_sel  (wr_sel),
         .wr_val  (wr_data[DW-1:0]),
         .clr     (cmd_clr),
         .load    (cmd_load),
         .code_q  (data_flat[g*DW +: DW]),
         .hold_q  (out_code[g*DW +: DW]),
         .range_q (out_coarse[g*CG_W +: CG_W]),
         .fine_q  (out_fine[g*FG_W +: FG_W]),
         .ofs_q   (out_ofs[g*OF_W +: OF_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_strobe <= 1'b0;
      else        out_strobe <= cmd_load;
   end

   dacupd_rdmux #(
      .NCH(NCH), .DW(DW), .CG_W(CG_W), .FG_W(FG_W), .OF_W(OF_W), .BUS_W(BUS_W)
   ) u_rd (
      .rd_addr    (rd_addr),
      .code_flat  (data_flat),
      .range_flat (out_coarse),
      .fine_flat  (out_fine),
      .ofs_flat   (out_ofs),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/dacupd_chk.sv
module dacupd_chk #(
   parameter int NCH      = 8,
   parameter int DW       = 16,
   parameter int CG_W     = 2,
   parameter int CG_RSVD  = 3,
   parameter int BUS_W    = 32,
   parameter int LOAD_BIT = 31,
   parameter int CLR_BIT  = 30,
   localparam int AW      = $clog2(NCH) + 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [AW-1:0]       wr_addr,
   input logic [BUS_W-1:0]    wr_data,
   input logic [BUS_W-1:0]    rd_data,
   input logic [NCH*DW-1:0]   out_code,
   input logic                out_strobe,
   input logic [NCH*CG_W-1:0] out_coarse,
   input logic [NCH*DW-1:0]   data_flat
);
   logic ld, cl, dw;
   assign ld = wr_en && wr_data[LOAD_BIT];
   assign cl = wr_en && wr_data[CLR_BIT];
   assign dw = wr_en && !wr_addr[AW-1] && wr_addr[1:0] == 2'd0;

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(out_code));

   p_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (out_code == data_flat));

   p_cmdzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[LOAD_BIT] == 1'b0) && (rd_data[CLR_BIT] == 1'b0));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cl && !dw) |=> (data_flat == '0));

   p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> !out_strobe);

   p_strobe_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> out_strobe);

   for (genvar g = 0; g < NCH; g++) begin : g_lane
      p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_coarse[g*CG_W +: CG_W] != CG_W'(CG_RSVD));
   end
endmodule

bind dacupd_ctrl dacupd_chk #(
   .NCH(NCH), .DW(DW), .CG_W(CG_W), .CG_RSVD(CG_RSVD), .BUS_W(BUS_W),
   .LOAD_BIT(LOAD_BIT), .CLR_BIT(CLR_BIT)
) u_chk (.*);

// File: tb/sim_dacupd_ctrl.sv
`timescale 1ns/100ps
module sim_dacupd_ctrl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [5:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [5:0]   rd_addr = '0;
   logic [31:0]  rd_data;
   logic [127:0] out_code;
   logic         out_strobe;
   logic [15:0]  out_coarse;
   logic [47:0]  out_fine;
   logic [63:0]  out_ofs;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [15:0]  m_data [8];
   logic [127:0] last_out = '0;
   logic [127:0] q[$];

   always #2.5 clk = ~clk;

   dacupd_ctrl u0 (.*);

   function automatic logic [127:0] image();
      logic [127:0] r;
      for (int i = 0; i < 8; i++) r[i*16 +: 16] = m_data[i];
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // driver: one write, expected image pushed on load
   task automatic wr(input logic [5:0] a, input logic [15:0] d,
                     input bit ld, input bit cl);
      wr_en = 1'b1; wr_addr = a; wr_data = {ld, cl, 14'b0, d};
      if (cl) for (int i = 0; i < 8; i++) m_data[i] = '0;
      if (!a[5] && a[1:0] == 2'd0) m_data[a[4:2]] = d;
      if (ld) begin last_out = image(); q.push_back(last_out); end
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      chk(rd_data == exp, tag, 128'(rd_data), 128'(exp));
   endtask

   // monitor: compare each strobe against the queued image
   always @(negedge clk) begin
      if (rst_n && out_strobe) begin
         if (q.size() == 0) chk(1'b0, "R11 unexpected strobe", 1, 0);
         else begin
            logic [127:0] e;
            e = q.pop_front();
            chk(out_code == e, "R2 load image", out_code, e);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_data[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      chk(out_code == '0, "R8 code", out_code, 0);
      chk(out_strobe == 1'b0, "R8 strobe", 128'(out_strobe), 0);
      chk({out_coarse, out_fine, out_ofs} == '0, "R8 trims",
          128'({out_coarse, out_fine, out_ofs}), 0);
      rd({1'b0, 3'd5, 2'd1}, 0, "R8 range read");
      @(negedge clk);
      // stage codes, no load: R1 and R5
      for (int i = 0; i < 8; i++)
         wr({1'b0, 3'(i), 2'd0}, 16'h1000 * 16'(i) + 16'h00A5, 1'b0, 1'b0);
      chk(out_code == '0, "R1 staged only", out_code, 0);
      for (int i = 0; i < 8; i++)
         rd({1'b0, 3'(i), 2'd0}, 32'(m_data[i]), "R5 readback");
      rd(6'h20, 0, "R3 command region");
      @(negedge clk);
      // load command only
      wr(6'h20, 16'h0, 1'b1, 1'b0);
      @(negedge clk);
      chk(out_strobe == 1'b0, "R11 single pulse", 128'(out_strobe), 0);
      chk(out_code == last_out, "R2 held", out_code, last_out);
      // staging differs from output
      wr({1'b0, 3'd3, 2'd0}, 16'hBEEF, 1'b0, 1'b0);
      rd({1'b0, 3'd3, 2'd0}, 32'h0000BEEF, "R5 staged not output");
      chk(out_code == last_out, "R1 after write", out_code, last_out);
      // range set before clear, to confirm clear leaves it
      wr({1'b0, 3'd2, 2'd1}, 16'h0002, 1'b0, 1'b0);
      // clear alone
      wr(6'h20, 16'h0, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) rd({1'b0, 3'(i), 2'd0}, 0, "R4 cleared");
      chk(out_code == last_out, "R4 output kept", out_code, last_out);
      rd({1'b0, 3'd2, 2'd1}, 2, "R4 trim kept");
      rd({1'b0, 3'd2, 2'd0} | 6'h0, 0, "R3 read bits");
      wr(6'h20, 16'h0, 1'b1, 1'b0);
      @(negedge clk);
      chk(out_code == '0, "R4 loaded zeros", out_code, 0);
      // same-cycle write and load
      wr({1'b0, 3'd6, 2'd0}, 16'h7777, 1'b1, 1'b0);
      chk(out_code[6*16 +: 16] == 16'h7777, "R9 new value loaded",
          128'(out_code[6*16 +: 16]), 128'h7777);
      // clear + write + load together
      wr({1'b0, 3'd0, 2'd0}, 16'hFFFF, 1'b0, 1'b0);
      wr({1'b0, 3'd7, 2'd0}, 16'h8000, 1'b0, 1'b0);
      wr({1'b0, 3'd1, 2'd0}, 16'h1234, 1'b1, 1'b1);
      chk(out_code == {96'h0, 16'h1234, 16'h0}, "R10 clear write load",
          out_code, {96'h0, 16'h1234, 16'h0});
      // range register and reserved code
      wr({1'b0, 3'd2, 2'd1}, 16'h0001, 1'b0, 1'b0);
      rd({1'b0, 3'd2, 2'd1}, 1, "R6 range 1");
      wr({1'b0, 3'd2, 2'd1}, 16'h0003, 1'b0, 1'b0);
      rd({1'b0, 3'd2, 2'd1}, 1, "R6 reserved ignored");
      chk(out_coarse[5:4] == 2'd1, "R6 lane kept", 128'(out_coarse[5:4]), 1);
      // trims
      wr({1'b0, 3'd4, 2'd2}, 16'h0020, 1'b0, 1'b0);
      rd({1'b0, 3'd4, 2'd2}, 32'h20, "R7 fine -32");
      chk(out_fine[4*6 +: 6] == 6'h20, "R7 fine lane",
          128'(out_fine[4*6 +: 6]), 128'h20);
      wr({1'b0, 3'd4, 2'd3}, 16'h0081, 1'b0, 1'b0);
      rd({1'b0, 3'd4, 2'd3}, 32'h81, "R7 offset");
      wr({1'b0, 3'd4, 2'd2}, 16'hFFC5, 1'b0, 1'b0);
      rd({1'b0, 3'd4, 2'd2}, 32'h05, "R7 fine truncated");
      chk(out_ofs[4*8 +: 8] == 8'h81, "R7 offset lane",
          128'(out_ofs[4*8 +: 8]), 128'h81);
      repeat (2) @(negedge clk);
      chk(q.size() == 0, "R2 all loads seen", 128'(q.size()), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule